// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address used by a synchronous burst memory port. On each rising clock edge it either captures a fresh external address, steps the two low address bits to the next word of a four-word burst, or keeps the current address. The upper address bits come from the captured address and do not change during a burst. Only the two low bits move, and they wrap inside the four-word group.

A burst starts when either of two start strobes is high and every chip enable is at its active level. From then on, each cycle with the advance input high moves to the next beat. A static order input selects how the low bits move. Linear order adds the beat number to the captured low bits, modulo 4. Interleaved order XORs the beat number into them. Bursts are optional: the address can be reloaded on every cycle. The beat position is kept in a four-state machine with the states BEAT0, BEAT1, BEAT2 and BEAT3. It has three transitions. LOAD goes from any state to BEAT0. ADVANCE goes from BEATn to BEAT(n+1 mod 4). HOLD keeps the present state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with no start or advance, `addr_o` is 0 and the beat is BEAT0.
- R2: When `start_a_i` is high at a rising edge and all chip enables are active, `addr_o` equals the `addr_i` sampled at that edge from that edge onward.
- R3: `start_b_i` loads the address in the same way as `start_a_i`, and both strobes high together perform a single load.
- R4: A chip enable counts as active when `ce_i[k]` equals `CE_POL[k]` (default `CE_POL`=3'b010, so bit 1 is active high and bits 0 and 2 are active low). A start strobe seen while any enable is inactive does not load the address, and the cycle is then handled as if no strobe were present.
- R5: During an advance, bits `ADDR_W-1:2` of `addr_o` keep their loaded value.
- R6: With `ord_i`=0 (linear), after k advances the low two bits equal (loaded low bits + k) mod 4.
- R7: With `ord_i`=1 (interleaved, the level a pull-up strap gives), after k advances the low two bits equal the loaded low bits XOR (k mod 4).
- R8: A start strobe that is honoured wins over `adv_i` in the same cycle: the address loads and the beat returns to BEAT0.
- R9: With no honoured start and `adv_i` low, `addr_o` holds its value.
- R10: After four advances the address returns to the loaded address.
- R11: A new address can be loaded on consecutive cycles, and each one appears on `addr_o` right after its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| start_a_i | input | 1 | First burst-start strobe, active high |
| start_b_i | input | 1 | Second burst-start strobe, active high |
| adv_i | input | 1 | Advance to the next beat, active high |
| ord_i | input | 1 | Order select: 0 linear, 1 interleaved |
| ce_i | input | NUM_CE | Chip enables, levels given by CE_POL |
| addr_o | output | ADDR_W | Current access address |

## Verification
The beat state and the captured address feed `addr_o` with no register between them. A wrong beat state therefore shows up as wrong low address bits on the very cycle after the edge that produced it. A wrong captured address shows up in the upper bits in that same cycle. A missed or extra step makes every later beat of the burst wrong, and it is most visible at the wrap back to the loaded address. The bench keeps its own reference model of base and step count and compares `addr_o` after every edge, so any divergence is caught one cycle after its cause.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;

    typedef enum logic [1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_e;

    typedef enum logic [1:0] {
        EV_HOLD = 2'd0,
        EV_LOAD = 2'd1,
        EV_ADV  = 2'd2
    } agen_ev_e;

    function automatic beat_e beat_after(beat_e b);
        beat_e n;
        unique case (b)
            BEAT0: n = BEAT1;
            BEAT1: n = BEAT2;
            BEAT2: n = BEAT3;
            BEAT3: n = BEAT0;
            default: n = BEAT0;
        endcase
        return n;
    endfunction

    function automatic logic [1:0] order_low(logic [1:0] base, beat_e b, logic inter);
        logic [1:0] r;
        if (inter) r = base ^ logic'(1'b0) ^ 2'(b);
        else       r = base + 2'(b);
        return r;
    endfunction

endpackage

// File: rtl/ce_qualify.sv
module ce_qualify #(
    parameter int               NUM_CE = 3,
    parameter logic [NUM_CE-1:0] CE_POL = 3'b010
) (
    input  logic [NUM_CE-1:0] ce_i,
    output logic              all_on_o
);
    logic [NUM_CE-1:0] hit;

    for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
        if (CE_POL[g]) begin : g_high
            assign hit[g] = ce_i[g];
        end else begin : g_low
            assign hit[g] = ~ce_i[g];
        end
    end

    assign all_on_o = &hit;
endmodule

// File: rtl/agen_event_dec.sv
module agen_event_dec
    import burst_agen_pkg::*;
(
    input  logic     start_a_i,
    input  logic     start_b_i,
    input  logic     adv_i,
    input  logic     ce_ok_i,
    output agen_ev_e ev_o
);
    logic start_any;

    assign start_any = start_a_i | start_b_i;

    always_comb begin
        if (start_any && ce_ok_i) ev_o = EV_LOAD;
        else if (adv_i)           ev_o = EV_ADV;
        else                      ev_o = EV_HOLD;
    end
endmodule

// File: rtl/beat_fsm.sv
module beat_fsm
    import burst_agen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  agen_ev_e ev_i,
    output beat_e    beat_o
);
    beat_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BEAT0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (ev_i)
            EV_LOAD: state_d = BEAT0;
            EV_ADV:  state_d = beat_after(state_q);
            EV_HOLD: state_d = state_q;
            default: state_d = state_q;
        endcase
    end

    always_comb begin
        beat_o = state_q;
    end

    assert_adv_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_ADV) |=> (state_q == beat_after($past(state_q))));

    assert_load_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_LOAD) |=> (state_q == BEAT0));

    assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_HOLD) |=> $stable(state_q));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_agen_pkg::*;
#(
    parameter int                ADDR_W = 15,
    parameter int                NUM_CE = 3,
    parameter logic [NUM_CE-1:0] CE_POL = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_a_i,
    input  logic              start_b_i,
    input  logic              adv_i,
    input  logic              ord_i,
    input  logic [NUM_CE-1:0] ce_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - 2;

    logic              ce_ok;
    agen_ev_e          ev;
    beat_e             beat;
    logic [UP_W-1:0]   upper_q;
    logic [1:0]        base_lo_q;

    ce_qualify #(.NUM_CE(NUM_CE), .CE_POL(CE_POL)) i_ce (
        .ce_i     (ce_i),
        .all_on_o (ce_ok)
    );

    agen_event_dec i_dec (
        .start_a_i (start_a_i),
        .start_b_i (start_b_i),
        .adv_i     (adv_i),
        .ce_ok_i   (ce_ok),
        .ev_o      (ev)
    );

    beat_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev),
        .beat_o (beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q   <= '0;
            base_lo_q <= '0;
        end else if (ev == EV_LOAD) begin
            upper_q   <= addr_i[ADDR_W-1:2];
            base_lo_q <= addr_i[1:0];
        end
    end

    always_comb begin
        addr_o = {upper_q, order_low(base_lo_q, beat, ord_i)};
    end

    assert_load_takes_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_LOAD) |=> (addr_o == $past(addr_i)));

    assert_gated_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_a_i || start_b_i) && !ce_ok && !adv_i) |=>
        ((addr_o == $past(addr_o)) || (ord_i != $past(ord_i))));

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ADV) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ADV && !ord_i) |=>
        (ord_i || (addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1))));

    assert_inter_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ADV && ord_i && beat == BEAT0) |=>
        (!ord_i || (addr_o[1:0] == ($past(addr_o[1:0]) ^ 2'b01))));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_HOLD) |=> ((addr_o == $past(addr_o)) || (ord_i != $past(ord_i))));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          start_a_i = 1'b0, start_b_i = 1'b0, adv_i = 1'b0, ord_i = 1'b1;
    logic [2:0]    ce_i = 3'b010;
    logic [AW-1:0] addr_o;

    int total = 0, bad = 0;
    int m_base = 0, m_step = 0;
    bit done = 0;

    always #10 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .start_a_i(start_a_i),
        .start_b_i(start_b_i), .adv_i(adv_i), .ord_i(ord_i), .ce_i(ce_i),
        .addr_o(addr_o)
    );

    function automatic int expect_addr(int base, int step, logic ord);
        int lo;
        lo = ord ? ((base & 3) ^ step) : (((base & 3) + step) % 4);
        return (base & ~3) | lo;
    endfunction

    task automatic check(input string tag, input int exp);
        total++;
        if (int'(addr_o) != exp) begin
            bad++;
            $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp[AW-1:0]);
        end
    endtask

    task automatic cyc(input logic sa, input logic sb, input logic adv, input logic ord,
                       input logic [2:0] ce, input int a, input string tag);
        start_a_i = sa; start_b_i = sb; adv_i = adv; ord_i = ord; ce_i = ce;
        addr_i = a[AW-1:0];
        @(posedge clk);
        if ((sa || sb) && ce == 3'b010) begin
            m_base = a & ((1 << AW) - 1);
            m_step = 0;
        end else if (adv) begin
            m_step = (m_step + 1) % 4;
        end
        @(negedge clk);
        check(tag, expect_addr(m_base, m_step, ord));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 1, 3'b010, 0, "R1 after release");

        cyc(1, 0, 0, 0, 3'b010, 'h1235, "R2 load A");
        cyc(0, 0, 1, 0, 3'b010, 0, "R5 upper fixed");
        cyc(0, 0, 1, 0, 3'b010, 0, "R6 linear beat2");
        cyc(0, 0, 1, 0, 3'b010, 0, "R6 linear beat3");
        cyc(0, 0, 1, 0, 3'b010, 0, "R10 linear wrap");

        cyc(0, 1, 0, 1, 3'b010, 'h2A41, "R3 load B");
        cyc(0, 0, 1, 1, 3'b010, 0, "R7 inter beat1");
        cyc(0, 0, 1, 1, 3'b010, 0, "R7 inter beat2");
        cyc(0, 0, 1, 1, 3'b010, 0, "R7 inter beat3");
        cyc(0, 0, 1, 1, 3'b010, 0, "R10 inter wrap");
        cyc(0, 0, 0, 1, 3'b010, 0, "R9 hold");
        cyc(0, 0, 0, 1, 3'b010, 0, "R9 hold again");

        cyc(1, 0, 0, 1, 3'b011, 'h7777, "R4 ce0 inactive");
        cyc(0, 1, 1, 1, 3'b000, 'h5550, "R4 ce1 inactive adv");
        cyc(1, 1, 0, 1, 3'b110, 'h0003, "R4 ce2 inactive");
        cyc(1, 0, 1, 1, 3'b010, 'h3C06, "R8 start beats adv");
        cyc(1, 1, 0, 1, 3'b010, 'h0102, "R3 both strobes");
        cyc(1, 0, 0, 0, 3'b010, 'h4441, "R11 back to back");
        cyc(0, 1, 0, 0, 3'b010, 'h1113, "R11 back to back");
        cyc(1, 0, 1, 1, 3'b010, 'h7FFE, "R11 back to back");
        cyc(0, 0, 1, 1, 3'b010, 0, "R7 after reload");

        for (int i = 0; i < 400; i++) begin
            logic sa, sb, ad, od;
            logic [2:0] ce;
            int a;
            string tag;
            sa = ($urandom % 4) == 0;
            sb = ($urandom % 5) == 0;
            ad = ($urandom % 3) != 0;
            od = (i / 50) % 2 == 0;
            ce = (($urandom % 6) == 0) ? 3'($urandom) : 3'b010;
            a  = int'($urandom % (1 << AW));
            if ((sa || sb) && ce == 3'b010) tag = sa ? "R2 random" : "R3 random";
            else if (sa || sb)              tag = "R4 random";
            else if (ad)                    tag = od ? "R7 random" : "R6 random";
            else                            tag = "R9 random";
            cyc(sa, sb, ad, od, ce, a, tag);
        end

        rst_n = 1'b0;
        #1;
        check("R1 reset again", 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule